// File: doc/BRIEF.md
# Radio Core Sleep and Wake Sequencer

This block decides when a radio core's crystal oscillator may stop and when it has to run again. A serial register port can post a write that asks the core to stop. The request takes effect when that serial transaction ends: the sequencer spends a fixed number of reference cycles winding down and then drops the oscillator enable. When automatic mode is selected, the same wind-down also starts when a packet finishes.

While the core is asleep, the register port stays usable. A transmit or receive command restarts the oscillator. The sequencer then waits out a programmable restart period before it reports the clock as ready. At that point it can pulse a one-cycle event toward the interrupt logic.

The block also holds the 3-bit threshold code for the low-battery comparator. It enables that comparator only while the oscillator is running and settled, so monitoring is always off during sleep.

Top module: `radio_sleep_seq`

## Requirements
- R1: A pulse on `xact_wr` with `xact_force_end`=1 and `xact_end_code`=3'b000 arms a sleep request. A write with any other combination disarms it. While the sequencer is awake and a request is armed, a pulse on `xact_done` starts the wind-down. `osc_en` is then low after the (ENTRY_CYCLES+1)-th rising edge, counting the edge that samples `xact_done` as the first. Without an armed request, `xact_done` has no effect.
- R2: The wind-down never lasts more than ENTRY_LIMIT cycles. ENTRY_LIMIT is CLK_MHZ × 35, the 35 µs entry bound expressed at the reference rate.
- R3: When `auto_sleep_en`=1, a pulse on `pkt_done` while awake starts the same wind-down with the same timing as R1. When `auto_sleep_en`=0, `pkt_done` has no effect.
- R4: `osc_en` is low only while asleep. While asleep, writes on `xact_wr` and `thr_wr` are still accepted.
- R5: A `txrx_cmd` pulse while asleep raises `osc_en` at the edge that samples it. A `txrx_cmd` pulse during the wind-down cancels the wind-down and the core stays awake. A `txrx_cmd` pulse while fully awake has no effect.
- R6: After a wake, `osc_ready` rises S edges after the edge that sampled `txrx_cmd`. S is the `settle_cycles` value captured at wake, with 0 treated as 1. When `stable_irq_en`=1, `osc_stable_irq` is high for exactly the first cycle in which `osc_ready` is high. Otherwise it stays low.
- R7: `lb_mon_en` is high exactly when `osc_ready`=1 and `lb_thresh` is not 3'b000. Code 000 means monitoring is off, and codes 001 to 111 select the seven thresholds from 1.8 V to 2.7 V.
- R8: `lb_thresh` resets to 3'b000, loads `thr_code` on a `thr_wr` pulse in any state, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xact_wr | input | 1 | Strobe: transaction-control register written |
| xact_force_end | input | 1 | Force-end bit of that write |
| xact_end_code | input | 3 | End-state field of that write |
| xact_done | input | 1 | Strobe: last serial clock edge of a transaction |
| auto_sleep_en | input | 1 | Sleep automatically after each packet |
| pkt_done | input | 1 | Strobe: packet transmission or reception finished |
| txrx_cmd | input | 1 | Strobe: transmit or receive command |
| settle_cycles | input | SETTLE_W | Oscillator restart wait, in reference cycles |
| stable_irq_en | input | 1 | Enable the oscillator-stable event |
| thr_wr | input | 1 | Strobe: load low-battery threshold code |
| thr_code | input | 3 | Threshold code to load |
| osc_en | output | 1 | Oscillator enable |
| osc_ready | output | 1 | Oscillator running and settled |
| osc_stable_irq | output | 1 | One-cycle oscillator-stable event |
| lb_mon_en | output | 1 | Low-battery comparator enable |
| lb_thresh | output | 3 | Current threshold code |

## Verification
The main sleep and wake cycle is run under four combinations. Each combination varies the entry path (an explicit write or the end of a packet), the settle count (0, 1, 5 and 12), the threshold code (including 000) and whether the stable event is enabled. Measuring the exact edge counts on these separates an off-by-one in either timer from correct timing, and a saturated zero count from a wrapped one. Writes that do not ask for sleep, packets seen with automatic mode off, and commands issued while awake or during the wind-down show whether each trigger is qualified by the right state. Register writes made while asleep show whether the serial path still works with the oscillator stopped.

// File: rtl/radio_sleep_pkg.sv
package radio_sleep_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_ENTER  = 2'd1,
    PS_SLEEP  = 2'd2,
    PS_SETTLE = 2'd3
  } pwr_state_e;

  // A write asks for sleep only with force-end set and a zero end state.
  function automatic logic is_sleep_req(input logic force_end, input logic [2:0] end_code);
    return force_end && (end_code == 3'b000);
  endfunction

  // Converts a time bound in microseconds to reference cycles.
  function automatic int unsigned bound_cycles(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction

endpackage

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (start)   count <= '0;
    else if (run)     count <= count + 1'b1;
  end

  assign done = run && (count == limit - 1'b1);

  // The count never passes the limit while the timer runs.
  p_count_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |-> (count < limit));

endmodule

// File: rtl/lowbat_gate.sv
module lowbat_gate #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_wr,
  input  logic [CODE_W-1:0] thr_code,
  input  logic              awake,
  output logic [CODE_W-1:0] thr_q,
  output logic              mon_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_wr) thr_q <= thr_code;
  end

  assign mon_en = awake && (thr_q != '0);

  p_thresh_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_wr |=> $stable(thr_q));

  p_thresh_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (thr_q == $past(thr_code)));

endmodule

// File: rtl/radio_sleep_seq.sv
module radio_sleep_seq
  import radio_sleep_pkg::*;
#(
  parameter int unsigned CLK_MHZ        = 200,
  parameter int unsigned ENTRY_BOUND_US = 35,
  parameter int unsigned ENTRY_CYCLES   = 8,
  parameter int unsigned SETTLE_W       = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xact_wr,
  input  logic                xact_force_end,
  input  logic [2:0]          xact_end_code,
  input  logic                xact_done,
  input  logic                auto_sleep_en,
  input  logic                pkt_done,
  input  logic                txrx_cmd,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                stable_irq_en,
  input  logic                thr_wr,
  input  logic [2:0]          thr_code,
  output logic                osc_en,
  output logic                osc_ready,
  output logic                osc_stable_irq,
  output logic                lb_mon_en,
  output logic [2:0]          lb_thresh
);

  localparam int unsigned ENTRY_LIMIT = bound_cycles(CLK_MHZ, ENTRY_BOUND_US);
  localparam int unsigned EW          = $clog2(ENTRY_CYCLES + 1);
  localparam logic [EW-1:0] ENTRY_LIM = EW'(ENTRY_CYCLES);

  // A programmed settle count of zero still waits one cycle.
  function automatic logic [SETTLE_W-1:0] eff_settle(input logic [SETTLE_W-1:0] s);
    return (s == '0) ? SETTLE_W'(1) : s;
  endfunction

  pwr_state_e state, state_nx;
  logic       sleep_arm, arm_now;
  logic [SETTLE_W-1:0] settle_lim;

  // Named events, shared by the next-state logic and the assertions
  logic ev_wr_sleep, ev_pkt_sleep, ev_start_entry;
  logic ev_wake, ev_abort, ev_entry_done, ev_settle_done;
  logic [EW-1:0]       entry_cnt;
  logic [SETTLE_W-1:0] settle_cnt;

  assign arm_now        = xact_wr ? is_sleep_req(xact_force_end, xact_end_code) : sleep_arm;
  assign ev_wr_sleep    = (state == PS_ACTIVE) && xact_done && arm_now;
  assign ev_pkt_sleep   = (state == PS_ACTIVE) && auto_sleep_en && pkt_done;
  assign ev_start_entry = ev_wr_sleep || ev_pkt_sleep;
  assign ev_wake        = (state == PS_SLEEP) && txrx_cmd;
  assign ev_abort       = (state == PS_ENTER) && txrx_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sleep_arm <= 1'b0;
    else if (ev_wr_sleep) sleep_arm <= 1'b0;
    else if (xact_wr)     sleep_arm <= is_sleep_req(xact_force_end, xact_end_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       settle_lim <= SETTLE_W'(1);
    else if (ev_wake) settle_lim <= eff_settle(settle_cycles);
  end

  cycle_timer #(.W(EW)) u_entry_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_start_entry),
    .run   (state == PS_ENTER),
    .limit (ENTRY_LIM),
    .done  (ev_entry_done),
    .count (entry_cnt)
  );

  cycle_timer #(.W(SETTLE_W)) u_settle_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_wake),
    .run   (state == PS_SETTLE),
    .limit (settle_lim),
    .done  (ev_settle_done),
    .count (settle_cnt)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      PS_ACTIVE: if (ev_start_entry) state_nx = PS_ENTER;
      PS_ENTER: begin
        if (ev_abort)           state_nx = PS_ACTIVE;
        else if (ev_entry_done) state_nx = PS_SLEEP;
      end
      PS_SLEEP:  if (ev_wake)        state_nx = PS_SETTLE;
      PS_SETTLE: if (ev_settle_done) state_nx = PS_ACTIVE;
      default:   state_nx = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= PS_ACTIVE;
      osc_stable_irq <= 1'b0;
    end else begin
      state          <= state_nx;
      osc_stable_irq <= ev_settle_done && stable_irq_en;
    end
  end

  assign osc_en    = (state != PS_SLEEP);
  assign osc_ready = (state == PS_ACTIVE) || (state == PS_ENTER);

  lowbat_gate #(.CODE_W(3)) u_lowbat (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr_wr   (thr_wr),
    .thr_code (thr_code),
    .awake    (osc_ready),
    .thr_q    (lb_thresh),
    .mon_en   (lb_mon_en)
  );

  // Checker: counts cycles spent winding down, to bound entry without unrolling
  int unsigned entry_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  entry_age <= 0;
    else if (state == PS_ENTER)  entry_age <= entry_age + 1;
    else                         entry_age <= 0;
  end

  p_write_starts_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_ACTIVE) && xact_done && arm_now) |=> (state == PS_ENTER));

  p_entry_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ENTER) |-> (entry_age < ENTRY_LIMIT));

  p_entry_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ENTER) |-> (entry_cnt < ENTRY_LIM));

  p_auto_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_ACTIVE) && auto_sleep_en && pkt_done) |=> (state == PS_ENTER));

  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && txrx_cmd) |=> (osc_en && !osc_ready));

  p_irq_after_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stable_irq |-> (osc_ready && $past(state == PS_SETTLE)));

  p_settle_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SETTLE) |-> (settle_cnt < settle_lim));

  p_mon_off_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !lb_mon_en);

endmodule

// File: tb/radio_sleep_seq_tb.sv
`timescale 1ns/1ps
module radio_sleep_seq_tb_top;

  localparam int E        = 8;
  localparam int LIMIT    = 200 * 35;
  localparam int NVEC     = 4;
  // Vector table: settle count, threshold, stable event enable, entry path (1 = packet)
  localparam int          V_SETTLE [NVEC] = '{5, 0, 1, 12};
  localparam logic [2:0]  V_THR    [NVEC] = '{3'd1, 3'd7, 3'd0, 3'd4};
  localparam logic        V_IRQ    [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic        V_AUTO   [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, xact_wr, xact_force_end, xact_done, auto_sleep_en, pkt_done;
  logic txrx_cmd, stable_irq_en, thr_wr;
  logic [2:0] xact_end_code, thr_code, lb_thresh;
  logic [15:0] settle_cycles;
  logic osc_en, osc_ready, osc_stable_irq, lb_mon_en;

  radio_sleep_seq dut_i (
    .clk(clk), .rst_n(rst_n), .xact_wr(xact_wr), .xact_force_end(xact_force_end),
    .xact_end_code(xact_end_code), .xact_done(xact_done), .auto_sleep_en(auto_sleep_en),
    .pkt_done(pkt_done), .txrx_cmd(txrx_cmd), .settle_cycles(settle_cycles),
    .stable_irq_en(stable_irq_en), .thr_wr(thr_wr), .thr_code(thr_code),
    .osc_en(osc_en), .osc_ready(osc_ready), .osc_stable_irq(osc_stable_irq),
    .lb_mon_en(lb_mon_en), .lb_thresh(lb_thresh)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_xact(input logic fe, input logic [2:0] code);
    xact_wr = 1'b1; xact_force_end = fe; xact_end_code = code;
    tick();
    xact_wr = 1'b0; xact_force_end = 1'b0; xact_end_code = 3'd0;
  endtask

  task automatic write_thr(input logic [2:0] code);
    thr_wr = 1'b1; thr_code = code;
    tick();
    thr_wr = 1'b0;
  endtask

  // Pulses one trigger strobe and counts edges until osc_en drops.
  task automatic sleep_and_count(input logic use_pkt, output int n);
    if (use_pkt) pkt_done = 1'b1; else xact_done = 1'b1;
    tick();
    pkt_done = 1'b0; xact_done = 1'b0;
    n = 1;
    while (osc_en && n < 2000) begin
      tick();
      n++;
    end
  endtask

  // Pulses txrx_cmd from sleep; counts edges until osc_ready, noting the event.
  task automatic wake_and_count(output int n, output int early_irq, output int irq_at_ready);
    txrx_cmd = 1'b1;
    tick();
    txrx_cmd = 1'b0;
    n = 1;
    early_irq = 0;
    chk("R5 osc_en after wake edge", int'(osc_en), 1);
    while (!osc_ready && n < 2000) begin
      if (osc_stable_irq) early_irq = 1;
      tick();
      n++;
    end
    irq_at_ready = int'(osc_stable_irq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, early, irqr;
    rst_n = 1'b0; xact_wr = 1'b0; xact_force_end = 1'b0; xact_end_code = 3'd0;
    xact_done = 1'b0; auto_sleep_en = 1'b0; pkt_done = 1'b0; txrx_cmd = 1'b0;
    settle_cycles = 16'd0; stable_irq_en = 1'b0; thr_wr = 1'b0; thr_code = 3'd0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // Reset state
    chk("R4 reset osc_en", int'(osc_en), 1);
    chk("R6 reset osc_ready", int'(osc_ready), 1);
    chk("R6 reset irq", int'(osc_stable_irq), 0);
    chk("R8 reset threshold", int'(lb_thresh), 0);
    chk("R7 reset monitor", int'(lb_mon_en), 0);

    // Table-driven sleep/wake cycles
    for (int v = 0; v < NVEC; v++) begin
      write_thr(V_THR[v]);
      chk("R8 threshold load", int'(lb_thresh), int'(V_THR[v]));
      chk("R7 monitor awake", int'(lb_mon_en), int'(V_THR[v] != 3'd0));
      settle_cycles = 16'(V_SETTLE[v]);
      stable_irq_en = V_IRQ[v];
      auto_sleep_en = V_AUTO[v];
      if (!V_AUTO[v]) write_xact(1'b1, 3'b000);
      sleep_and_count(V_AUTO[v], n);
      if (V_AUTO[v]) chk("R3 packet entry edges", n, E + 1);
      else           chk("R1 write entry edges", n, E + 1);
      chk("R2 entry within bound", int'(n <= LIMIT), 1);
      auto_sleep_en = 1'b0;
      repeat (3) tick();
      chk("R4 stays asleep", int'(osc_en), 0);
      chk("R7 monitor off asleep", int'(lb_mon_en), 0);
      wake_and_count(n, early, irqr);
      chk("R6 settle edges", n, ((V_SETTLE[v] == 0) ? 1 : V_SETTLE[v]) + 1);
      chk("R6 no early event", early, 0);
      chk("R6 event at ready", irqr, int'(V_IRQ[v]));
      chk("R7 monitor after settle", int'(lb_mon_en), int'(V_THR[v] != 3'd0));
      tick();
      chk("R6 event one cycle", int'(osc_stable_irq), 0);
    end

    // R1: writes that do not request sleep disarm; xact_done then does nothing
    write_xact(1'b1, 3'b011);
    xact_done = 1'b1; tick(); xact_done = 1'b0;
    repeat (E + 3) tick();
    chk("R1 nonzero end code ignored", int'(osc_en), 1);
    write_xact(1'b1, 3'b000);
    write_xact(1'b0, 3'b000);
    xact_done = 1'b1; tick(); xact_done = 1'b0;
    repeat (E + 3) tick();
    chk("R1 later write disarms", int'(osc_en), 1);

    // R3: packet completion with automatic mode off
    auto_sleep_en = 1'b0;
    pkt_done = 1'b1; tick(); pkt_done = 1'b0;
    repeat (E + 3) tick();
    chk("R3 packet ignored when auto off", int'(osc_en), 1);

    // R5: command while awake has no effect
    stable_irq_en = 1'b1;
    txrx_cmd = 1'b1; tick(); txrx_cmd = 1'b0;
    chk("R5 command awake ready", int'(osc_ready), 1);
    repeat (3) tick();
    chk("R5 command awake no event", int'(osc_stable_irq), 0);
    chk("R5 command awake osc", int'(osc_en), 1);

    // R5: command during wind-down cancels it
    write_xact(1'b1, 3'b000);
    xact_done = 1'b1; tick(); xact_done = 1'b0;
    repeat (3) tick();
    txrx_cmd = 1'b1; tick(); txrx_cmd = 1'b0;
    repeat (E + 2) tick();
    chk("R5 abort keeps oscillator", int'(osc_en), 1);
    chk("R5 abort keeps ready", int'(osc_ready), 1);

    // R4/R8: register writes while asleep
    settle_cycles = 16'd2;
    write_xact(1'b1, 3'b000);
    sleep_and_count(1'b0, n);
    chk("R1 entry edges again", n, E + 1);
    write_thr(3'd6);
    chk("R8 threshold written asleep", int'(lb_thresh), 6);
    chk("R4 asleep after thr write", int'(osc_en), 0);
    chk("R7 monitor off with code set", int'(lb_mon_en), 0);
    write_xact(1'b1, 3'b000);
    chk("R4 asleep after xact write", int'(osc_en), 0);
    wake_and_count(n, early, irqr);
    chk("R6 settle two", n, 3);
    tick();
    // the request written while asleep is still armed
    sleep_and_count(1'b0, n);
    chk("R4 request written asleep kept", n, E + 1);
    wake_and_count(n, early, irqr);
    chk("R7 monitor restored", int'(lb_mon_en), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule